// File: doc/BRIEF.md
# Q15 Rounding Multiplier with Unity Mode

This block multiplies two 16-bit fractional operands and returns the high half of the product, rounded to the nearest step and fitted back into 16 bits. It has two numeric conventions, and a mode bit chooses one for each transaction.

In signed mode, each operand is an ordinary two's-complement fraction with fifteen fraction bits. In unity mode, the operands are non-negative pixel-style values between zero and one, and the code 0x8000 means +1.0 rather than -1.0. Unity mode lets 8-bit image data that has been widened to 16 bits keep its full range through steps such as gamma correction.

The multiplier is pipelined with a fixed two-cycle latency and accepts a new operand pair on every clock. A valid strobe travels alongside the data, and the output word holds its last value between results.

Top module: `q15_rmul`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and y_o is 0x0000.
- R2: In signed mode (mode_i = 0), both operands are two's complement with 15 fraction bits, so 0x8000 is -1.0. y_o is the low 16 bits of floor((a*b + 0x4000) / 2^15). For example, 0x8000 x 0x4000 gives 0xC000.
- R3: In signed mode, a rounded result above +32767 saturates to 0x7FFF, so 0x8000 x 0x8000 gives 0x7FFF. Signed mode never outputs 0x8000; for example, 0x8000 x 0x7FFF gives 0x8001.
- R4: In unity mode (mode_i = 1), the operands lie in 0x0000..0x8000 and 0x8000 stands for +1.0. y_o is the magnitude of the signed-mode rounded product, taken before saturation. For example, 0x8000 x 0x4000 gives 0x4000.
- R5: In unity mode, 0x8000 x 0x8000 gives 0x8000, and no unity result exceeds 0x8000.
- R6: A pair sampled with valid_i high at a rising edge produces valid_o high with its result after the second rising edge that follows. Back-to-back pairs are accepted on every cycle, and each pair keeps the mode it was sampled with.
- R7: While valid_o is low, y_o holds the last result. Operands and mode presented with valid_i low have no effect on y_o.
- R8: A zero operand gives 0x0000 in either mode.
- R9: Rounding takes an exact half step toward plus infinity. For example, 0x0001 x 0x4000 gives 0x0001, and 0xFFFF x 0x4000 gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair present |
| mode_i | input | 1 | 0 selects signed Q15, 1 selects unity convention |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| valid_o | output | 1 | Result present |
| y_o | output | 16 | Rounded, fitted product |

## Verification
The assertions assume that, in unity mode, both operands stay at or below 0x8000. Beyond that range, the unity ceiling and the magnitude rule have no meaning, and one assertion flags any such transaction at the input. The stimulus draws unity operands only from 0..0x8000 inclusive, with the 0x8000 endpoint forced in directed cases. Signed-mode operands cover the full 16-bit space. Operands with valid_i low may take any value, including out-of-range unity ones, because the hold requirement has to be shown against arbitrary idle inputs.

// File: rtl/q15_rmul_pkg.sv
package q15_rmul_pkg;
  typedef enum logic {
    MODE_SIGNED = 1'b0,
    MODE_UNITY  = 1'b1
  } q15_mode_e;
endpackage

// File: rtl/q15_valid_pipe.sv
module q15_valid_pipe #(
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic [DEPTH-1:0] taps_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic v_q;
    logic v_d;
    if (i == 0) begin : g_head
      assign v_d = valid_i;
    end else begin : g_tail
      assign v_d = g_stage[i-1].v_q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) v_q <= 1'b0;
      else         v_q <= v_d;
    end
    assign taps_o[i] = v_q;
  end
endmodule

// File: rtl/q15_mul_stage.sv
module q15_mul_stage
  import q15_rmul_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  q15_mode_e                mode_i,
  input  logic        [DATA_W-1:0] a_i,
  input  logic        [DATA_W-1:0] b_i,
  output logic signed [PROD_W-1:0] prod_o,
  output q15_mode_e                mode_o
);
  localparam logic [DATA_W-1:0] UNITY_ONE = DATA_W'(1) << (DATA_W - 1);

  logic signed [PROD_W-1:0] prod_d;
  assign prod_d = PROD_W'($signed(a_i)) * PROD_W'($signed(b_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_o <= '0;
      mode_o <= MODE_SIGNED;
    end else if (en_i) begin
      prod_o <= prod_d;
      mode_o <= mode_i;
    end
  end

  // input contract: unity operands never exceed +1.0
  assert_unity_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == MODE_UNITY) |-> (a_i <= UNITY_ONE && b_i <= UNITY_ONE));
endmodule

// File: rtl/q15_round_sat.sv
module q15_round_sat
  import q15_rmul_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned PROD_W = 2 * DATA_W,
  localparam int unsigned FRAC_W = DATA_W - 1
) (
  input  logic signed [PROD_W-1:0] prod_i,
  input  q15_mode_e                mode_i,
  output logic        [DATA_W-1:0] res_o
);
  localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] POS_MAX  = (PROD_W'(1) << FRAC_W) - PROD_W'(1);

  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] shifted;
  logic        [DATA_W-1:0] mag;

  assign biased  = prod_i + HALF_LSB;
  assign shifted = biased >>> FRAC_W;
  // |shifted| <= 2^FRAC_W, so the low DATA_W bits carry the whole magnitude
  assign mag     = shifted[PROD_W-1] ? (~shifted[DATA_W-1:0] + DATA_W'(1))
                                     : shifted[DATA_W-1:0];

  always_comb begin
    if (mode_i == MODE_UNITY)    res_o = mag;
    else if (shifted > POS_MAX)  res_o = POS_MAX[DATA_W-1:0];
    else                         res_o = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/q15_rmul.sv
module q15_rmul
  import q15_rmul_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] y_o
);
  localparam int unsigned PROD_W  = 2 * DATA_W;
  localparam int unsigned LAT     = 2;
  localparam logic [DATA_W-1:0] UNITY_ONE = DATA_W'(1) << (DATA_W - 1);

  logic [LAT-1:0]           vtap;
  logic signed [PROD_W-1:0] prod_q;
  q15_mode_e                mode_s1;
  logic [DATA_W-1:0]        res_d;
  logic [DATA_W-1:0]        y_q;
  q15_mode_e                mode_q;

  q15_valid_pipe #(.DEPTH(LAT)) u_vpipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .taps_o (vtap)
  );

  q15_mul_stage #(.DATA_W(DATA_W)) u_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (valid_i),
    .mode_i(q15_mode_e'(mode_i)),
    .a_i   (a_i),
    .b_i   (b_i),
    .prod_o(prod_q),
    .mode_o(mode_s1)
  );

  q15_round_sat #(.DATA_W(DATA_W)) u_rnd (
    .prod_i(prod_q),
    .mode_i(mode_s1),
    .res_o (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q    <= '0;
      mode_q <= MODE_SIGNED;
    end else if (vtap[0]) begin
      y_q    <= res_d;
      mode_q <= mode_s1;
    end
  end

  assign valid_o = vtap[LAT-1];
  assign y_o     = y_q;

  // cycles since reset, saturating; gates properties that look back
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                warm_q <= '0;
    else if (warm_q != 2'd3)    warm_q <= warm_q + 2'd1;
  end

  assert_valid_latency_R6: assert property (@(posedge clk_i)
    disable iff (!rst_ni || warm_q < 2'd2)
    valid_o == $past(valid_i, 2));

  assert_signed_no_min_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_q == MODE_SIGNED) |-> (y_o != UNITY_ONE));

  assert_unity_ceiling_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_q == MODE_UNITY) |-> (y_o <= UNITY_ONE));

  assert_zero_operand_R8: assert property (@(posedge clk_i)
    disable iff (!rst_ni || warm_q < 2'd2)
    (valid_o && $past(valid_i && (a_i == '0 || b_i == '0), 2)) |-> (y_o == '0));

  assert_hold_idle_R7: assert property (@(posedge clk_i)
    disable iff (!rst_ni || warm_q < 2'd1)
    !valid_o |-> $stable(y_o));
endmodule

// File: tb/tb_q15_rmul.sv
module tb_q15_rmul;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic        mode_i;
  logic [15:0] a_i;
  logic [15:0] b_i;
  logic        valid_o;
  logic [15:0] y_o;

  always #10 clk = ~clk;

  q15_rmul dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .valid_i(valid_i),
    .mode_i (mode_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .valid_o(valid_o),
    .y_o    (y_o)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  string tag_cur  = "R2";
  logic  qv[$];
  logic [15:0] qy[$];
  string qt[$];
  logic [15:0] exp_y = 16'h0000;

  function automatic logic [15:0] model(logic m, logic [15:0] a, logic [15:0] b);
    longint p, r;
    p = longint'($signed(a)) * longint'($signed(b));
    r = (p + 64'sd16384) >>> 15;
    if (m) begin
      if (r < 0) r = -r;
      return r[15:0];
    end
    if (r > 32767) return 16'h7FFF;
    return r[15:0];
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, expv, $time);
    end
  endtask

  // reference delay line: entry sampled at edge k is visible after edge k+1
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qv.delete(); qy.delete(); qt.delete();
      exp_y = 16'h0000;
    end else begin
      qv.push_back(valid_i);
      qy.push_back(model(mode_i, a_i, b_i));
      qt.push_back(tag_cur);
      if (qv.size() > 2) begin
        void'(qv.pop_front()); void'(qy.pop_front()); void'(qt.pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", {15'd0, valid_o}, 16'h0000);
      chk("R1", y_o, 16'h0000);
    end else begin
      logic ev;
      string t;
      ev = (qv.size() == 2) && qv[0];
      t  = ev ? qt[0] : "R7";
      if (ev) exp_y = qy[0];
      chk("R6", {15'd0, valid_o}, {15'd0, ev});
      chk(t, y_o, exp_y);
    end
  end

  task automatic send(logic v, logic m, logic [15:0] a, logic [15:0] b, string tag);
    @(negedge clk);
    valid_i = v; mode_i = m; a_i = a; b_i = b; tag_cur = tag;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; mode_i = 1'b0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 signed corners
    send(1, 0, 16'h8000, 16'h4000, "R2");
    send(1, 0, 16'h4000, 16'h4000, "R2");
    send(1, 0, 16'h7FFF, 16'h7FFF, "R2");
    // R3 saturation and near-minimum
    send(1, 0, 16'h8000, 16'h8000, "R3");
    send(1, 0, 16'h8000, 16'h7FFF, "R3");
    // R9 half-step rounding
    send(1, 0, 16'h0001, 16'h4000, "R9");
    send(1, 0, 16'hFFFF, 16'h4000, "R9");
    // R8 zero operand, both modes
    send(1, 0, 16'h0000, 16'h8000, "R8");
    send(1, 1, 16'h8000, 16'h0000, "R8");
    // R4 unity convention
    send(1, 1, 16'h8000, 16'h4000, "R4");
    send(1, 1, 16'h1234, 16'h8000, "R4");
    send(1, 1, 16'h4000, 16'h4000, "R4");
    // R5 unity one squared
    send(1, 1, 16'h8000, 16'h8000, "R5");
    // R7 idle with arbitrary operands
    for (int i = 0; i < 6; i++)
      send(0, i[0], 16'hFFFF - 16'(i), 16'h8001 + 16'(i), "R7");
    // R2 random signed, back to back
    for (int i = 0; i < 300; i++)
      send(1, 0, 16'($urandom), 16'($urandom), "R2");
    // R4 random unity within range
    for (int i = 0; i < 300; i++)
      send(1, 1, 16'($urandom_range(0, 32768)), 16'($urandom_range(0, 32768)), "R4");
    // R6 mode switching per cycle with gaps
    for (int i = 0; i < 200; i++) begin
      logic m;
      m = i[0];
      if (i % 7 == 3) send(0, m, 16'($urandom), 16'($urandom), "R7");
      else if (m) send(1, 1, 16'($urandom_range(0, 32768)), 16'h8000, "R6");
      else send(1, 0, 16'($urandom), 16'($urandom), "R6");
    end
    send(0, 0, 16'h0000, 16'h0000, "R7");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule